// File: doc/BRIEF.md
# Interrupt-Driven Memory Transfer Engine

This block is a small bus master that moves data on behalf of peripherals, so that the processor does no work for each transfer. Each interrupt source has an enable bit. When a source raises its request while its bit is set, the engine takes the source, fetches a pointer for it from a table in memory, and loads a six-word transfer descriptor. It then moves one item of data from a source address to a destination address, updates the descriptor, and writes it back. A chain bit in the descriptor makes the engine continue with the next descriptor in memory during the same activation.

At the end of an activation, one of two things happens. If no descriptor asked for a processor interrupt, the engine pulses the clear line of the peripheral and keeps its enable bit. Otherwise it clears the enable bit and leaves the peripheral flag set. The request then shows on the processor interrupt output. Software restores the enable bit when it wants transfers to resume.

Top module: `irq_xfer_engine`

## Requirements
- R1: `cpuIrq[i]` equals `srcReq[i] & ~enable[i]` at all times. A request from a source whose enable bit is 0 causes no bus activity. All enable bits reset to 0.
- R2: An activation starts with a longword read at `tableBase + 4*s`, where s is the served source. The descriptor address is `tableBase` plus the value that read returns.
- R3: The descriptor is six longwords at byte offsets 0 to 20: mode, count, source address, destination address, spare count, spare pointer. They are read in that order before the data move and written back in the same order after it. The spare fields come back unchanged.
- R4: Mode bits [1:0] give the data size: 0 is byte, 1 is word, 2 is longword, and 3 acts as longword. The same code appears on `memSize` for both the data read and the data write. Data is right-justified on `memRdata` and `memWdata`, and the bits above the size are written as zero.
- R5: Mode bits [3:2] (source) and [5:4] (destination) select the address update after the move: 1 adds the size in bytes, 2 subtracts it, and 0 or 3 holds the address. The updated addresses are written back.
- R6: The count is decremented by one on each move, modulo 2^32. A descriptor asks for a processor interrupt when the new count is zero or when mode bit 6 is 1.
- R7: If no descriptor of the activation asked for an interrupt, `srcClr` is one-hot on the served source for exactly one cycle, and the enable bit stays 1.
- R8: If any descriptor of the activation asked for an interrupt, the enable bit of the served source is cleared and `srcClr` stays 0. The flag therefore appears on `cpuIrq`.
- R9: When mode bit 7 of a descriptor is 1, the next descriptor is taken at its address plus 24 within the same activation. No further vector read takes place.
- R10: With several enabled requests pending, the lowest-numbered source is served first. Only one activation runs at a time, and the bus is idle while `busy` is 0.
- R11: While `memValid` is high and `memReady` is low, address, size, write enable and write data hold steady. Any number of wait cycles is accepted.
- R12: A cycle with `enWr` high loads all enable bits from `enWrData`. A source whose bit becomes 1 and whose request is pending is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC | Peripheral request flags |
| enWr | input | 1 | Load strobe for the enable register |
| enWrData | input | NUM_SRC | New enable bits |
| tableBase | input | DATA_W | Base address of the vector table |
| cpuIrq | output | NUM_SRC | Requests passed to the processor |
| srcClr | output | NUM_SRC | One-cycle flag clear to peripherals |
| busy | output | 1 | An activation is in progress |
| memValid | output | 1 | Bus request |
| memWe | output | 1 | Bus write enable |
| memSize | output | 2 | Bus size: 0 byte, 1 word, 2 longword |
| memAddr | output | DATA_W | Bus byte address |
| memWdata | output | DATA_W | Write data, right-justified |
| memReady | input | 1 | Bus completion |
| memRdata | input | DATA_W | Read data, right-justified |

## Verification
The hardest case to reach is a pileup: several enabled sources are pending at once, and one of them runs a chained descriptor pair whose second half ends in an interrupt. All of this happens while the bus inserts a varying number of wait states. The bench raises the flags of three sources in one cycle. It also gives one source a chain whose last count reaches zero, and it stretches every bus beat by zero to three pseudo-random wait cycles. A reference model predicts every beat from its own shadow memory, so the service order, the chained fetch and the final clear-or-disable choice are all checked beat by beat.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
  localparam int DESC_WORDS   = 6;
  localparam int WORD_BYTES   = 4;
  localparam int MODE_SRC_LO  = 2;
  localparam int MODE_DST_LO  = 4;
  localparam int MODE_IRQ_ANY = 6;
  localparam int MODE_CHAIN   = 7;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_VEC, BUS_DRD, BUS_SRC, BUS_DST, BUS_DWB
  } bus_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_DRD, ST_SRC, ST_DST, ST_DWB, ST_FIN
  } xfer_state_e;

  typedef struct packed {
    logic     start;
    logic     vecLoad;
    logic     descLoad;
    logic     dataLoad;
    logic     stepDesc;
    logic     nextDesc;
    bus_sel_e busSel;
    logic [2:0] idx;
  } ctl_strobe_t;
endpackage

// File: rtl/xfer_addr_step.sv
`timescale 1ns/1ps
module xfer_addr_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [1:0]   mode,
  input  logic [2:0]   nBytes,
  output logic [W-1:0] nxt
);
  always_comb begin
    case (mode)
      2'd1:    nxt = cur + W'(nBytes);
      2'd2:    nxt = cur - W'(nBytes);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/xfer_datapath.sv
`timescale 1ns/1ps
module xfer_datapath import xfer_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       ctl,
  input  logic [SRC_W-1:0]  srcIdx,
  input  logic [DATA_W-1:0] tableBase,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [1:0]        memSize,
  output logic              memWe,
  output logic              chainBit,
  output logic              irqHit
);
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;

  logic [DATA_W-1:0] descAddr, modeR, cntR, srcR, dstR, cntBR, auxR, dataR;
  logic              irqSticky;
  logic [1:0]        sizeCode;
  logic [2:0]        nBytes;
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] countNext;
  logic              hitNow;
  logic [DATA_W-1:0] idxOff;
  logic [DATA_W-1:0] wbWord;

  logic [DATA_W-1:0] stepIn  [2];
  logic [DATA_W-1:0] stepOut [2];
  logic [1:0]        stepMode[2];

  // size decode: code 3 is treated as longword
  always_comb begin
    sizeCode = (modeR[1:0] == 2'd3) ? SZ_LONG : modeR[1:0];
    case (sizeCode)
      SZ_BYTE: begin nBytes = 3'd1; sizeMask = DATA_W'(32'h0000_00FF); end
      SZ_WORD: begin nBytes = 3'd2; sizeMask = DATA_W'(32'h0000_FFFF); end
      default: begin nBytes = 3'd4; sizeMask = '1; end
    endcase
  end

  assign stepIn[0]   = srcR;
  assign stepIn[1]   = dstR;
  assign stepMode[0] = modeR[MODE_SRC_LO +: 2];
  assign stepMode[1] = modeR[MODE_DST_LO +: 2];

  for (genvar g = 0; g < 2; g++) begin : g_step
    xfer_addr_step #(.W(DATA_W)) u_step (
      .cur   (stepIn[g]),
      .mode  (stepMode[g]),
      .nBytes(nBytes),
      .nxt   (stepOut[g])
    );
  end

  assign countNext = cntR - DATA_W'(1);
  assign hitNow    = (countNext == '0) || modeR[MODE_IRQ_ANY];
  assign idxOff    = DATA_W'(ctl.idx) << 2;
  assign chainBit  = modeR[MODE_CHAIN];
  assign irqHit    = irqSticky;

  always_comb begin
    case (ctl.idx)
      3'd0:    wbWord = modeR;
      3'd1:    wbWord = cntR;
      3'd2:    wbWord = srcR;
      3'd3:    wbWord = dstR;
      3'd4:    wbWord = cntBR;
      default: wbWord = auxR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      modeR     <= '0;
      cntR      <= '0;
      srcR      <= '0;
      dstR      <= '0;
      cntBR     <= '0;
      auxR      <= '0;
      dataR     <= '0;
      irqSticky <= 1'b0;
    end else begin
      if (ctl.start)   irqSticky <= 1'b0;
      if (ctl.vecLoad) descAddr  <= tableBase + memRdata;
      if (ctl.descLoad) begin
        case (ctl.idx)
          3'd0:    modeR <= memRdata;
          3'd1:    cntR  <= memRdata;
          3'd2:    srcR  <= memRdata;
          3'd3:    dstR  <= memRdata;
          3'd4:    cntBR <= memRdata;
          default: auxR  <= memRdata;
        endcase
      end
      if (ctl.dataLoad) dataR <= memRdata & sizeMask;
      if (ctl.stepDesc) begin
        cntR <= countNext;
        srcR <= stepOut[0];
        dstR <= stepOut[1];
        if (hitNow) irqSticky <= 1'b1;
      end
      if (ctl.nextDesc) descAddr <= descAddr + DATA_W'(DESC_BYTES);
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memSize  = SZ_LONG;
    memWe    = 1'b0;
    case (ctl.busSel)
      BUS_VEC: memAddr = tableBase + (DATA_W'(srcIdx) << 2);
      BUS_DRD: memAddr = descAddr + idxOff;
      BUS_SRC: begin memAddr = srcR; memSize = sizeCode; end
      BUS_DST: begin
        memAddr  = dstR;
        memSize  = sizeCode;
        memWe    = 1'b1;
        memWdata = dataR;
      end
      BUS_DWB: begin
        memAddr  = descAddr + idxOff;
        memWe    = 1'b1;
        memWdata = wbWord;
      end
      default: memSize = SZ_BYTE;
    endcase
  end
endmodule

// File: rtl/xfer_ctrl.sv
`timescale 1ns/1ps
module xfer_ctrl import xfer_pkg::*; #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               memReady,
  input  logic               chainBit,
  input  logic               irqHit,
  output ctl_strobe_t        ctl,
  output logic [SRC_W-1:0]   srcIdx,
  output logic [NUM_SRC-1:0] srcClr,
  output logic [NUM_SRC-1:0] enReg,
  output logic               memValid,
  output logic               busy
);
  localparam logic [2:0] LAST_IDX = 3'(DESC_WORDS - 1);

  xfer_state_e       state;
  logic [2:0]        idx;
  logic [NUM_SRC-1:0] pending;
  logic [SRC_W-1:0]  win;
  logic              anyPend;
  logic              acc;

  // fixed priority: lowest index wins
  assign pending = srcReq & enReg;
  assign anyPend = |pending;
  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) win = SRC_W'(i);
    end
  end

  assign memValid = (state == ST_VEC) || (state == ST_DRD) || (state == ST_SRC) ||
                    (state == ST_DST) || (state == ST_DWB);
  assign acc  = memValid && memReady;
  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.idx      = idx;
    ctl.start    = (state == ST_IDLE) && anyPend;
    ctl.vecLoad  = (state == ST_VEC) && acc;
    ctl.descLoad = (state == ST_DRD) && acc;
    ctl.dataLoad = (state == ST_SRC) && acc;
    ctl.stepDesc = (state == ST_DST) && acc;
    ctl.nextDesc = (state == ST_DWB) && acc && (idx == LAST_IDX) && chainBit;
    case (state)
      ST_VEC:  ctl.busSel = BUS_VEC;
      ST_DRD:  ctl.busSel = BUS_DRD;
      ST_SRC:  ctl.busSel = BUS_SRC;
      ST_DST:  ctl.busSel = BUS_DST;
      ST_DWB:  ctl.busSel = BUS_DWB;
      default: ctl.busSel = BUS_NONE;
    endcase
  end

  assign srcClr = ((state == ST_FIN) && !irqHit) ? (NUM_SRC'(1) << srcIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      srcIdx <= '0;
      enReg  <= '0;
    end else begin
      if (enWr) enReg <= enWrData;
      // engine clear takes precedence over a simultaneous load
      if ((state == ST_FIN) && irqHit) enReg[srcIdx] <= 1'b0;
      case (state)
        ST_IDLE: if (anyPend) begin
          srcIdx <= win;
          state  <= ST_VEC;
        end
        ST_VEC: if (acc) begin
          idx   <= '0;
          state <= ST_DRD;
        end
        ST_DRD: if (acc) begin
          if (idx == LAST_IDX) state <= ST_SRC;
          else                 idx   <= idx + 3'd1;
        end
        ST_SRC: if (acc) state <= ST_DST;
        ST_DST: if (acc) begin
          idx   <= '0;
          state <= ST_DWB;
        end
        ST_DWB: if (acc) begin
          if (idx == LAST_IDX) begin
            idx   <= '0;
            state <= chainBit ? ST_DRD : ST_FIN;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_xfer_engine.sv
`timescale 1ns/1ps
module irq_xfer_engine import xfer_pkg::*; #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic [DATA_W-1:0]  tableBase,
  output logic [NUM_SRC-1:0] cpuIrq,
  output logic [NUM_SRC-1:0] srcClr,
  output logic               busy,
  output logic               memValid,
  output logic               memWe,
  output logic [1:0]         memSize,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic               memReady,
  input  logic [DATA_W-1:0]  memRdata
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctl_strobe_t        ctl;
  logic [SRC_W-1:0]   srcIdx;
  logic [NUM_SRC-1:0] enReg;
  logic               chainBit;
  logic               irqHit;

  xfer_ctrl #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .srcReq  (srcReq),
    .enWr    (enWr),
    .enWrData(enWrData),
    .memReady(memReady),
    .chainBit(chainBit),
    .irqHit  (irqHit),
    .ctl     (ctl),
    .srcIdx  (srcIdx),
    .srcClr  (srcClr),
    .enReg   (enReg),
    .memValid(memValid),
    .busy    (busy)
  );

  xfer_datapath #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcIdx   (srcIdx),
    .tableBase(tableBase),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memSize  (memSize),
    .memWe    (memWe),
    .chainBit (chainBit),
    .irqHit   (irqHit)
  );

  assign cpuIrq = srcReq & ~enReg;
endmodule

// File: rtl/irq_xfer_engine_chk.sv
`timescale 1ns/1ps
module irq_xfer_engine_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] cpuIrq,
  input logic [NUM_SRC-1:0] srcClr,
  input logic               busy,
  input logic               memValid,
  input logic               memWe,
  input logic [1:0]         memSize,
  input logic [DATA_W-1:0]  memAddr,
  input logic [DATA_W-1:0]  memWdata,
  input logic               memReady
);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memSize) &&
                              $stable(memWe) && $stable(memWdata));

  // R4
  size_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memSize != 2'd3);

  // R10
  one_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcClr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid && (srcClr == '0));

  // R7
  clr_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcClr != '0) |-> ((cpuIrq & srcClr) == '0));
endmodule

bind irq_xfer_engine irq_xfer_engine_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuIrq(cpuIrq), .srcClr(srcClr), .busy(busy),
  .memValid(memValid), .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady)
);

// File: tb/irq_xfer_engine_test.sv
`timescale 1ns/1ps
module irq_xfer_engine_test;
  localparam int NS = 8;
  localparam int DW = 32;
  localparam int MEMSZ = 4096;
  localparam int unsigned TBASE = 32'h100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] flg = '0;
  logic          enWr = 1'b0;
  logic [NS-1:0] enWrData = '0;
  logic [NS-1:0] cpuIrq, srcClr;
  logic          busy, memValid, memWe;
  logic [1:0]    memSize;
  logic [DW-1:0] memAddr, memWdata;
  logic          memReady = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #5 clk = ~clk;

  irq_xfer_engine #(.NUM_SRC(NS), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .srcReq(flg), .enWr(enWr), .enWrData(enWrData),
    .tableBase(TBASE), .cpuIrq(cpuIrq), .srcClr(srcClr), .busy(busy),
    .memValid(memValid), .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata)
  );

  typedef struct {
    bit          we;
    int          size;
    int unsigned addr;
    int unsigned data;
    string       tag;
  } beat_t;

  logic [7:0] mem [MEMSZ];
  logic [7:0] sh  [MEMSZ];
  beat_t      expQ[$];

  int nChk = 0, nFail = 0, cycles = 0, beats = 0;
  logic [NS-1:0] enModel = '0;
  bit  modelActive = 0, lastDone = 0, expIrq = 0, clrSeen = 0;
  int  cur = 0;
  bit  fresh = 1;
  int  waitLeft = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned nb(input int size);
    return (size == 0) ? 1 : (size == 1) ? 2 : 4;
  endfunction

  function automatic int unsigned shRd(input int unsigned a, input int n);
    int unsigned v = 0;
    for (int k = 0; k < n; k++) v |= int'(sh[(a + k) % MEMSZ]) << (8 * k);
    return v;
  endfunction

  function automatic void shWr(input int unsigned a, input int unsigned v, input int n);
    for (int k = 0; k < n; k++) sh[(a + k) % MEMSZ] = 8'(v >> (8 * k));
  endfunction

  function automatic int unsigned memRd(input int unsigned a, input int n);
    int unsigned v = 0;
    for (int k = 0; k < n; k++) v |= int'(mem[(a + k) % MEMSZ]) << (8 * k);
    return v;
  endfunction

  function automatic void memWr(input int unsigned a, input int unsigned v, input int n);
    for (int k = 0; k < n; k++) mem[(a + k) % MEMSZ] = 8'(v >> (8 * k));
  endfunction

  function automatic void putLong(input int unsigned a, input int unsigned v);
    shWr(a, v, 4);
    memWr(a, v, 4);
  endfunction

  function automatic void pushBeat(input bit we, input int size, input int unsigned a,
                                   input int unsigned d, input string tag);
    beat_t b;
    b.we = we; b.size = size; b.addr = a; b.data = d; b.tag = tag;
    expQ.push_back(b);
  endfunction

  function automatic int unsigned stepAddr(input int unsigned a, input int mode, input int unsigned n);
    if (mode == 1) return a + n;
    if (mode == 2) return a - n;
    return a;
  endfunction

  // behavioural model of one activation, working on the shadow image
  function automatic void buildActivation(input int s);
    int unsigned d, w[6], v, n;
    int sz;
    bit irq = 0;
    pushBeat(0, 2, TBASE + 4 * s, 0, "R2/R10 vector read");
    d = TBASE + shRd(TBASE + 4 * s, 4);
    forever begin
      for (int k = 0; k < 6; k++) begin
        w[k] = shRd(d + 4 * k, 4);
        pushBeat(0, 2, d + 4 * k, 0, "R3/R9 descriptor read");
      end
      sz = int'(w[0] & 3);
      if (sz == 3) sz = 2;
      n = nb(sz);
      pushBeat(0, sz, w[2], 0, "R4 data read");
      v = shRd(w[2], n);
      pushBeat(1, sz, w[3], v, "R4 data write");
      shWr(w[3], v, n);
      w[1] = w[1] - 1;
      if (w[1] == 0 || w[0][6]) irq = 1;
      w[2] = stepAddr(w[2], int'((w[0] >> 2) & 3), n);
      w[3] = stepAddr(w[3], int'((w[0] >> 4) & 3), n);
      for (int k = 0; k < 6; k++) begin
        pushBeat(1, 2, d + 4 * k, w[k], "R3/R5/R6 write-back");
        shWr(d + 4 * k, w[k], 4);
      end
      if (!w[0][7]) break;
      d = d + 24;
    end
    expIrq = irq;
    cur = s;
    modelActive = 1;
    lastDone = 0;
    clrSeen = 0;
  endfunction

  // monitor, bus responder and reference comparison, all at the falling edge
  always @(negedge clk) begin
    beat_t b;
    int unsigned mask, rd;
    logic [NS-1:0] pend;
    cycles++;
    if (rstN) begin
      if (enWr) enModel = enWrData;
      if (srcClr != '0) begin
        check(modelActive && lastDone && !expIrq && srcClr == NS'(1 << cur),
              "R7", "flag clear pulse", srcClr, modelActive ? (1 << cur) : 0);
        flg = flg & ~srcClr;
        clrSeen = 1;
      end
      if (!memValid) begin
        memReady = 1'b0;
        fresh = 1;
      end else begin
        if (fresh) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          waitLeft = int'(lfsr[1:0]);
          fresh = 0;
        end
        if (waitLeft == 0) begin
          memReady = 1'b1;
          fresh = 1;
          beats++;
          rd = memRd(memAddr, nb(memSize));
          memRdata = memWe ? '0 : rd;
          if (memWe) memWr(memAddr, memWdata, nb(memSize));
          if (expQ.size() == 0) begin
            check(0, "R10", "unexpected bus beat", memAddr, 0);
          end else begin
            b = expQ.pop_front();
            mask = (b.size == 0) ? 32'hFF : (b.size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            check(memWe == b.we && int'(memSize) == b.size && memAddr == b.addr,
                  b.tag, "beat kind/size/addr", {memWe, memSize, memAddr},
                  {b.we, 2'(b.size), b.addr});
            if (b.we)
              check(memWdata == (b.data & mask), b.tag, "write data", memWdata, b.data & mask);
            if (expQ.size() == 0) lastDone = 1;
          end
        end else begin
          memReady = 1'b0;
          waitLeft--;
        end
      end
      if (modelActive && lastDone && !busy) begin
        if (expIrq) begin
          check(!clrSeen && flg[cur], "R8", "flag kept, no clear", {clrSeen, flg[cur]}, 1);
          enModel[cur] = 1'b0;
        end else begin
          check(clrSeen, "R7", "clear pulse seen", clrSeen, 1);
        end
        modelActive = 0;
      end
      if (!busy && !modelActive && !enWr)
        check(cpuIrq == (flg & ~enModel), "R1/R8", "cpu request", cpuIrq, flg & ~enModel);
      if (!modelActive && !busy) begin
        pend = flg & enModel;
        if (pend != '0) begin
          for (int i = NS - 1; i >= 0; i--) if (pend[i]) cur = i;
          buildActivation(cur);
        end
      end
    end
    if (cycles > 100000) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic setEnable(input logic [NS-1:0] v);
    @(posedge clk); #1 enWr = 1'b1; enWrData = v;
    @(posedge clk); #1 enWr = 1'b0;
  endtask

  task automatic raise(input logic [NS-1:0] m);
    @(posedge clk); #1 flg = flg | m;
  endtask

  task automatic dropFlags(input logic [NS-1:0] m);
    @(posedge clk); #1 flg = flg & ~m;
  endtask

  task automatic waitQuiet();
    do @(negedge clk); while (modelActive || busy || (flg & enModel) != '0);
    repeat (3) @(negedge clk);
  endtask

  function automatic void setDesc(input int unsigned a, input int unsigned mode,
                                  input int unsigned cnt, input int unsigned src,
                                  input int unsigned dst);
    putLong(a, mode);
    putLong(a + 4, cnt);
    putLong(a + 8, src);
    putLong(a + 12, dst);
    putLong(a + 16, 32'hB000_0000 | a);
    putLong(a + 20, 32'hA000_0000 | a);
  endfunction

  function automatic int unsigned descOf(input int s);
    return 32'h200 + 32'h40 * s;
  endfunction

  initial begin
    int b0;
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = 8'(i * 7 + 3);
      sh[i]  = 8'(i * 7 + 3);
    end
    for (int s = 0; s < NS; s++) putLong(TBASE + 4 * s, descOf(s) - TBASE);
    // mode: [1:0] size, [3:2] src step, [5:4] dst step, [6] irq each, [7] chain
    setDesc(descOf(2), 32'h16, 3, 32'h800, 32'hC00);
    setDesc(descOf(0), 32'h48, 10, 32'h820, 32'hC40);
    setDesc(descOf(5), 32'h95, 5, 32'h840, 32'hC80);
    setDesc(descOf(5) + 24, 32'h22, 1, 32'h850, 32'hCA0);
    setDesc(descOf(6), 32'h96, 9, 32'h860, 32'hCC0);
    setDesc(descOf(6) + 24, 32'h15, 9, 32'h870, 32'hCE0);
    setDesc(descOf(1), 32'h17, 50, 32'h880, 32'hD00);
    setDesc(descOf(4), 32'h14, 50, 32'h890, 32'hD40);
    setDesc(descOf(3), 32'h16, 1, 32'h8A0, 32'hD80);

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R10", "reset busy", busy, 0);
    check(!memValid, "R10", "reset bus idle", memValid, 0);
    check(srcClr == '0, "R7", "reset clear lines", srcClr, 0);
    check(cpuIrq == '0, "R1", "reset cpu request", cpuIrq, 0);

    // R1: enable bits reset to zero, request goes to the cpu only
    raise(NS'(1 << 3));
    b0 = beats;
    repeat (20) @(negedge clk);
    check(beats == b0, "R1", "no bus beat while disabled", beats, b0);
    check(cpuIrq == NS'(1 << 3), "R1", "disabled request forwarded", cpuIrq, 1 << 3);
    dropFlags(NS'(1 << 3));

    // R7/R6/R5: longword, both addresses incrementing, count 3
    setEnable(NS'(1 << 2));
    raise(NS'(1 << 2));
    waitQuiet();
    check(memRd(descOf(2) + 4, 4) == 2, "R6", "count written back", memRd(descOf(2) + 4, 4), 2);
    check(memRd(descOf(2) + 8, 4) == 32'h804, "R5", "source incremented",
          memRd(descOf(2) + 8, 4), 32'h804);
    check(flg[2] == 1'b0 && cpuIrq[2] == 1'b0, "R7", "flag cleared, no cpu request",
          {flg[2], cpuIrq[2]}, 0);
    raise(NS'(1 << 2));
    waitQuiet();
    raise(NS'(1 << 2));
    waitQuiet();
    // R8: count reached zero on the third move
    check(cpuIrq[2] == 1'b1, "R8", "count zero passes request", cpuIrq[2], 1);
    check(memRd(descOf(2) + 4, 4) == 0, "R6", "count at zero", memRd(descOf(2) + 4, 4), 0);
    dropFlags(NS'(1 << 2));

    // R4/R5/R6: byte, decrementing source, fixed destination, irq every move
    setEnable(NS'(1 << 0));
    raise(NS'(1 << 0));
    waitQuiet();
    check(memRd(descOf(0) + 8, 4) == 32'h81F, "R5", "source decremented",
          memRd(descOf(0) + 8, 4), 32'h81F);
    check(memRd(descOf(0) + 12, 4) == 32'hC40, "R5", "destination held",
          memRd(descOf(0) + 12, 4), 32'hC40);
    check(cpuIrq[0] == 1'b1, "R6", "irq-every mode passes request", cpuIrq[0], 1);
    dropFlags(NS'(1 << 0));

    // R9: chained pair ending in an interrupt
    setEnable(NS'(1 << 5));
    raise(NS'(1 << 5));
    waitQuiet();
    check(cpuIrq[5] == 1'b1, "R9", "chain end count zero", cpuIrq[5], 1);
    check(memRd(descOf(5) + 24 + 12, 4) == 32'hC9C, "R9", "second descriptor dst down",
          memRd(descOf(5) + 36, 4), 32'hC9C);
    dropFlags(NS'(1 << 5));

    // R10: three sources at once, lowest served first; chain without interrupt on 6
    setEnable(NS'((1 << 1) | (1 << 4) | (1 << 6)));
    raise(NS'((1 << 1) | (1 << 4) | (1 << 6)));
    waitQuiet();
    check(flg == '0, "R10", "all three served and cleared", flg, 0);
    check(cpuIrq == '0, "R9", "chain without interrupt", cpuIrq, 0);

    // R12: pending disabled request starts once its bit is loaded
    raise(NS'(1 << 3));
    repeat (5) @(negedge clk);
    check(!busy, "R12", "still disabled", busy, 0);
    setEnable(NS'(1 << 3));
    waitQuiet();
    check(cpuIrq[3] == 1'b1 && flg[3] == 1'b1, "R12", "served after load",
          {cpuIrq[3], flg[3]}, 3);
    dropFlags(NS'(1 << 3));
    repeat (5) @(negedge clk);

    begin
      int bad = 0;
      for (int i = 0; i < MEMSZ; i++) if (mem[i] !== sh[i]) bad++;
      check(bad == 0, "R3", "memory image vs model", bad, 0);
    end
    check(expQ.size() == 0, "R3", "no outstanding beats", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule